// File: doc/BRIEF.md
# I2C DMA Handshake and Acknowledge Control

This block sits between the byte engine of an I2C controller and one DMA channel. While DMA mode is on, each transmit-register-empty event (in transmit direction) or receive-register-full event (in receive direction) becomes a request level toward the DMA. That level is held until the DMA pulses its acknowledge. It then stays low for a programmable gap before it may rise again. An event that arrives during the acknowledge cycle or during the gap is remembered and issued once the gap has ended.

The DMA reports back in two ways. It pulses an end-of-transfer indication, which sets a status flag and, when enabled, an interrupt. In master receive it also pulses a one-before-last indication when its remaining count reaches one. If the last-transfer enable is set, that pulse arms a NACK decision, so the following received byte is answered with NACK without CPU help. A byte that finishes shifting while a request is still unserviced raises a sticky overrun/underrun flag. A new start condition clears all of this state, and so does turning DMA mode off.

Top module: `i2c_dma_hs`

## Requirements
- R1: `dma_req_o` is 0 in every cycle that follows a cycle in which `dma_en_i` was 0, and no event raises it while DMA mode is off.
- R2: With `dir_i`=0 (transmit), a one-cycle `tx_empty_i` pulse raises `dma_req_o` at the next clock edge, and `rx_full_i` has no effect on `dma_req_o`.
- R3: With `dir_i`=1 (receive), a one-cycle `rx_full_i` pulse raises `dma_req_o` at the next clock edge, and `tx_empty_i` has no effect on `dma_req_o`.
- R4: `dma_req_o` stays high until `dma_ack_i` is sampled high, and it is low in the cycle after that. It then stays low for GAP_CYC cycles (default 1). An event seen during the acknowledge cycle or during the gap raises the request when the gap ends.
- R5: `byte_done_i` sampled while `dma_req_o` is high sets `ovr_o` at the next edge. `ovr_o` stays set until a start condition occurs or DMA mode is turned off.
- R6: With DMA on, `dir_i`=1 and `last_nack_en_i`=1, a `dma_eot_1_i` pulse sets `nack_o` (1 = answer with NACK, 0 = ACK) at the next edge. With `last_nack_en_i`=0, `nack_o` stays 0.
- R7: `nack_o` returns to 0 at the edge after `start_det_i` is sampled high, or at the edge after `dma_en_i` is sampled low.
- R8: A `dma_eot_i` pulse with DMA on sets `eot_flag_o` at the next edge. `eot_irq_o` equals `eot_flag_o` AND `eot_irq_en_i`. The flag clears on a start condition or when DMA mode is turned off.
- R9: `buf_irq_en_i` and `dma_en_i` must never both be 1. Requests are produced only when `dma_en_i`=1 and `buf_irq_en_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | DMA mode enable |
| buf_irq_en_i | input | 1 | Buffer-event interrupt enable (exclusive with DMA mode) |
| dir_i | input | 1 | Transfer direction: 0 transmit, 1 receive |
| last_nack_en_i | input | 1 | Enable automatic NACK after the one-before-last indication |
| eot_irq_en_i | input | 1 | End-of-transfer interrupt enable |
| tx_empty_i | input | 1 | Transmit data register empty event, one-cycle pulse |
| rx_full_i | input | 1 | Receive data register full event, one-cycle pulse |
| byte_done_i | input | 1 | Current byte finished shifting, one-cycle pulse |
| start_det_i | input | 1 | Start condition seen, one-cycle pulse |
| dma_ack_i | input | 1 | DMA serviced the request, one-cycle pulse |
| dma_eot_i | input | 1 | DMA end of transfer, one-cycle pulse |
| dma_eot_1_i | input | 1 | DMA remaining count reached one, one-cycle pulse |
| dma_req_o | output | 1 | DMA request level |
| nack_o | output | 1 | Acknowledge choice for the next received byte: 1 NACK |
| ovr_o | output | 1 | Sticky overrun/underrun flag |
| eot_flag_o | output | 1 | Sticky end-of-transfer flag |
| eot_irq_o | output | 1 | End-of-transfer interrupt |

## Verification
The checker relies on these inputs never having DMA mode and the buffer interrupt enabled at the same time. It also relies on the DMA acknowledging only while a request is visible. The bench raises `buf_irq_en_i` only while `dma_en_i` is low, and it pulses `dma_ack_i` only after it has seen `dma_req_o` high. All event inputs are driven as one-cycle pulses on the falling clock edge. The one exception is the queued-event case, where an event is deliberately placed in the same cycle as an acknowledge.

// File: rtl/i2c_dma_hs_pkg.sv
package i2c_dma_hs_pkg;
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;

  localparam int unsigned FLAG_OVR = 0;
  localparam int unsigned FLAG_EOT = 1;
  localparam int unsigned NUM_FLAGS = 2;
endpackage

// File: rtl/hs_req_gen.sv
module hs_req_gen #(
  parameter int unsigned GAP_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic event_i,
  input  logic ack_i,
  output logic req_o
);
  localparam int unsigned GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CYC - 1);

  logic          req_q;
  logic          held_q;
  logic [GW-1:0] gap_q;
  logic          ev;

  assign ev = active_i & event_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      held_q <= 1'b0;
      gap_q  <= '0;
    end else if (!active_i) begin
      req_q  <= 1'b0;
      held_q <= 1'b0;
      gap_q  <= '0;
    end else if (req_q && ack_i) begin
      req_q  <= 1'b0;
      held_q <= ev;
      gap_q  <= GAP_LOAD;
    end else if (!req_q) begin
      if (gap_q != '0) begin
        gap_q  <= gap_q - 1'b1;
        held_q <= held_q | ev;
      end else if (ev || held_q) begin
        req_q  <= 1'b1;
        held_q <= 1'b0;
      end
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/hs_nack_ctrl.sv
module hs_nack_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic rx_dir_i,
  input  logic last_en_i,
  input  logic eot_1_i,
  input  logic start_i,
  output logic nack_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              armed_q <= 1'b0;
    else if (start_i || !active_i)            armed_q <= 1'b0;
    else if (eot_1_i && rx_dir_i && last_en_i) armed_q <= 1'b1;
  end

  assign nack_o = armed_q;
endmodule

// File: rtl/hs_sticky.sv
module hs_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= 1'b0;
      else if (clr_i)    f_q <= 1'b0;
      else if (set_i[g]) f_q <= 1'b1;
    end
    assign flag_o[g] = f_q;
  end
endmodule

// File: rtl/i2c_dma_hs.sv
module i2c_dma_hs
  import i2c_dma_hs_pkg::*;
#(
  parameter int unsigned GAP_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_en_i,
  input  logic buf_irq_en_i,
  input  logic dir_i,
  input  logic last_nack_en_i,
  input  logic eot_irq_en_i,
  input  logic tx_empty_i,
  input  logic rx_full_i,
  input  logic byte_done_i,
  input  logic start_det_i,
  input  logic dma_ack_i,
  input  logic dma_eot_i,
  input  logic dma_eot_1_i,
  output logic dma_req_o,
  output logic nack_o,
  output logic ovr_o,
  output logic eot_flag_o,
  output logic eot_irq_o
);
  logic                 active;
  logic                 rx_dir;
  logic                 event_sel;
  logic                 req;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flags;

  // conflicting configuration keeps the request path silent
  assign active    = dma_en_i & ~buf_irq_en_i;
  assign rx_dir    = (dir_e'(dir_i) == DIR_RX);
  assign event_sel = rx_dir ? rx_full_i : tx_empty_i;

  hs_req_gen #(.GAP_CYC(GAP_CYC)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .event_i (event_sel),
    .ack_i   (dma_ack_i),
    .req_o   (req)
  );

  hs_nack_ctrl u_nack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (dma_en_i),
    .rx_dir_i (rx_dir),
    .last_en_i(last_nack_en_i),
    .eot_1_i  (dma_eot_1_i),
    .start_i  (start_det_i),
    .nack_o   (nack_o)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_OVR] = byte_done_i & req;
    flag_set[FLAG_EOT] = dma_eot_i & dma_en_i;
  end

  hs_sticky #(.N(NUM_FLAGS)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start_det_i | ~dma_en_i),
    .set_i (flag_set),
    .flag_o(flags)
  );

  assign dma_req_o  = req;
  assign ovr_o      = flags[FLAG_OVR];
  assign eot_flag_o = flags[FLAG_EOT];
  assign eot_irq_o  = flags[FLAG_EOT] & eot_irq_en_i;
endmodule

// File: rtl/i2c_dma_hs_chk.sv
module i2c_dma_hs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dma_en_i,
  input logic buf_irq_en_i,
  input logic dir_i,
  input logic last_nack_en_i,
  input logic eot_irq_en_i,
  input logic byte_done_i,
  input logic start_det_i,
  input logic dma_ack_i,
  input logic dma_eot_i,
  input logic dma_eot_1_i,
  input logic dma_req_o,
  input logic nack_o,
  input logic ovr_o,
  input logic eot_flag_o,
  input logic eot_irq_o
);
  a_r1_off_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |=> !dma_req_o);

  a_r4_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && !dma_ack_i && dma_en_i && !buf_irq_en_i |=> dma_req_o);

  a_r4_drop_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && dma_ack_i |=> !dma_req_o);

  a_r5_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i && dma_req_o && dma_en_i && !start_det_i |=> ovr_o);

  a_r6_arm_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_en_i && dir_i && last_nack_en_i && dma_eot_1_i && !start_det_i |=> nack_o);

  a_r7_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_i |=> !nack_o && !ovr_o && !eot_flag_o);

  a_r8_eot_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_eot_i && dma_en_i && !start_det_i |=> eot_flag_o);

  a_r8_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_irq_o |-> eot_irq_en_i && eot_flag_o);

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dma_en_i && buf_irq_en_i));
endmodule

bind i2c_dma_hs i2c_dma_hs_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dma_en_i      (dma_en_i),
  .buf_irq_en_i  (buf_irq_en_i),
  .dir_i         (dir_i),
  .last_nack_en_i(last_nack_en_i),
  .eot_irq_en_i  (eot_irq_en_i),
  .byte_done_i   (byte_done_i),
  .start_det_i   (start_det_i),
  .dma_ack_i     (dma_ack_i),
  .dma_eot_i     (dma_eot_i),
  .dma_eot_1_i   (dma_eot_1_i),
  .dma_req_o     (dma_req_o),
  .nack_o        (nack_o),
  .ovr_o         (ovr_o),
  .eot_flag_o    (eot_flag_o),
  .eot_irq_o     (eot_irq_o)
);

// File: tb/i2c_dma_hs_tb_top.sv
module i2c_dma_hs_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dma_en, buf_irq_en, dir, last_nack_en, eot_irq_en;
  logic tx_empty, rx_full, byte_done, start_det, dma_ack, dma_eot, dma_eot_1;
  logic dma_req, nack, ovr, eot_flag, eot_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_dma_hs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .dma_en_i(dma_en), .buf_irq_en_i(buf_irq_en),
    .dir_i(dir), .last_nack_en_i(last_nack_en), .eot_irq_en_i(eot_irq_en),
    .tx_empty_i(tx_empty), .rx_full_i(rx_full), .byte_done_i(byte_done),
    .start_det_i(start_det), .dma_ack_i(dma_ack), .dma_eot_i(dma_eot),
    .dma_eot_1_i(dma_eot_1), .dma_req_o(dma_req), .nack_o(nack), .ovr_o(ovr),
    .eot_flag_o(eot_flag), .eot_irq_o(eot_irq)
  );

  // {dir, tx_empty, rx_full, dma_en, expected req}
  localparam logic [4:0] VECS [6] = '{
    5'b0_1_0_1_1,  // R2 tx event
    5'b0_0_1_1_0,  // R2 rx event ignored in tx
    5'b1_0_1_1_1,  // R3 rx event
    5'b1_1_0_1_0,  // R3 tx event ignored in rx
    5'b0_1_0_0_0,  // R1 dma off, tx
    5'b1_0_1_0_0   // R1 dma off, rx
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clr_pulses();
    tx_empty = 0; rx_full = 0; byte_done = 0; start_det = 0;
    dma_ack = 0; dma_eot = 0; dma_eot_1 = 0;
  endtask

  task automatic ack_req();
    dma_ack = 1; cyc(); dma_ack = 0; cyc();
  endtask

  initial begin
    dma_en = 0; buf_irq_en = 0; dir = 0; last_nack_en = 0; eot_irq_en = 0;
    clr_pulses();
    repeat (3) cyc();
    rst_ni = 1;
    cyc();
    chk("R1 reset req", dma_req, 0);
    chk("R6 reset nack", nack, 0);
    chk("R5 reset ovr", ovr, 0);
    chk("R8 reset eot", eot_flag, 0);

    for (int i = 0; i < 6; i++) begin
      dir = VECS[i][4]; dma_en = VECS[i][1];
      cyc();
      tx_empty = VECS[i][3]; rx_full = VECS[i][2];
      cyc();
      clr_pulses();
      chk($sformatf("R1/R2/R3 vec%0d req", i), dma_req, VECS[i][0]);
      if (dma_req) ack_req();
      cyc();
    end

    // R4 hold and drop
    dma_en = 1; dir = 0; cyc();
    tx_empty = 1; cyc(); tx_empty = 0;
    repeat (3) cyc();
    chk("R4 held", dma_req, 1);
    dma_ack = 1; tx_empty = 1; cyc(); clr_pulses();
    chk("R4 dropped after ack", dma_req, 0);
    cyc();
    chk("R4 queued event raised", dma_req, 1);
    ack_req();
    chk("R4 idle after ack", dma_req, 0);

    // R5 overrun
    tx_empty = 1; cyc(); tx_empty = 0;
    chk("R5 pre ovr", ovr, 0);
    byte_done = 1; cyc(); byte_done = 0;
    chk("R5 ovr set", ovr, 1);
    cyc();
    chk("R5 ovr sticky", ovr, 1);
    start_det = 1; cyc(); start_det = 0;
    chk("R5 ovr cleared", ovr, 0);
    ack_req();

    // R6/R7 nack
    dir = 1; last_nack_en = 0; dma_eot_1 = 1; cyc(); dma_eot_1 = 0;
    chk("R6 no nack without enable", nack, 0);
    last_nack_en = 1; dma_eot_1 = 1; cyc(); dma_eot_1 = 0;
    chk("R6 nack armed", nack, 1);
    rx_full = 1; cyc(); rx_full = 0;
    chk("R6 nack held", nack, 1);
    ack_req();
    start_det = 1; cyc(); start_det = 0;
    chk("R7 nack cleared by start", nack, 0);
    dma_eot_1 = 1; cyc(); dma_eot_1 = 0;
    chk("R6 nack re-armed", nack, 1);
    dma_en = 0; cyc();
    chk("R7 nack cleared by disable", nack, 0);

    // R8 eot flag and irq
    dma_en = 1; eot_irq_en = 0; cyc();
    dma_eot = 1; cyc(); dma_eot = 0;
    chk("R8 eot flag", eot_flag, 1);
    chk("R8 irq masked", eot_irq, 0);
    eot_irq_en = 1; #1;
    chk("R8 irq enabled", eot_irq, 1);
    start_det = 1; cyc(); start_det = 0;
    chk("R8 flag cleared", eot_flag, 0);
    chk("R8 irq cleared", eot_irq, 0);

    // R1 disable drops live request
    dir = 0; tx_empty = 1; cyc(); tx_empty = 0;
    chk("R1 req before disable", dma_req, 1);
    dma_en = 0; cyc();
    chk("R1 req dropped on disable", dma_req, 0);

    // R9 buffer interrupt mode, DMA off
    buf_irq_en = 1; tx_empty = 1; cyc(); tx_empty = 0; cyc();
    chk("R9 no req in buffer irq mode", dma_req, 0);
    buf_irq_en = 0;
    cyc();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule